// File: doc/BRIEF.md
# Radio Transceiver Start-Up Sequencer

This block brings a radio transceiver out of reset into a known receive-ready configuration. After system reset, or whenever a one-cycle start request arrives, it holds the transceiver's active-low hardware reset line low for a timed interval. It then releases that line and waits a second interval of the same length. Only then does it play back a fixed script of register writes. The wake line is driven high throughout.

Each write goes out through a simple request port: a space-select bit (short or long register space), an address and a data byte, all held with a valid flag until a downstream register-access engine answers with a done pulse. That engine owns the serial bus and its chip select, which stays idle whenever no request is pending.

The script starts and ends with a pulse on the RF state-machine reset bit, so the configuration in between takes effect. Once the last write has been acknowledged, a ready flag rises and stays high until the next start request. Both wait intervals are derived from a clock-frequency parameter and a microsecond parameter.

Top module: `radio_boot_seq`

## Requirements
- R1: After reset is released, or after the cycle in which `init_req` is sampled high, `xcvr_rst_n` is low for exactly WAIT_CYC = CLK_HZ/1_000_000 × HOLD_US cycles. `xcvr_wake` is high at all times, including during reset.
- R2: After `xcvr_rst_n` rises, exactly WAIT_CYC cycles pass with `xcvr_rst_n` high and `wr_valid` low before the first write request appears.
- R3: A request stays valid, with `wr_long`, `wr_addr` and `wr_data` unchanged, until it is completed. A write is complete in a cycle where `wr_valid` and `wr_done` are both high. The next script entry is presented in the very next cycle.
- R4: The script has 18 entries, issued in this order (`wr_long` = 0 for short space, 1 for long space; addresses are hex). Short 36←04, short 36←00, short 01←AA, short 02←AA, short 03←AA, short 04←AA, short 0D←01, long 202←80, long 203←00, long 206←80, long 208←10, short 3A←78, short 3E←40, short 3F←00, long 200←00, short 00←01, short 36←04, short 36←00.
- R5: The first two and the last two writes form an RF reset pulse: short register 36 receives 04 and then 00.
- R6: `ready` is low from reset or a start request until the final write completes. It is high in the cycle after that completion and stays high, with `wr_valid` low, until the next start request.
- R7: `init_req` restarts the whole sequence from any state. In the following cycle `xcvr_rst_n`, `ready` and `wr_valid` are low, and the script later resumes from its first entry.
- R8: `wr_done` while `wr_valid` is low is ignored. It neither shortens the wait intervals nor advances the script, and it does not disturb `ready`.
- R9: During reset, `ready` and `wr_valid` are low and `xcvr_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | One-cycle start request; restarts the sequence |
| xcvr_rst_n | output | 1 | Active-low hardware reset to the transceiver |
| xcvr_wake | output | 1 | Wake line to the transceiver, held high |
| wr_valid | output | 1 | Write request pending |
| wr_long | output | 1 | Register space: 0 short, 1 long |
| wr_addr | output | 10 | Register address |
| wr_data | output | 8 | Write data |
| wr_done | input | 1 | Write completed by the access engine |
| ready | output | 1 | Script finished, transceiver configured |

## Verification
The hardest case to reach from the ports is a restart request that lands in the middle of the script, while a write is pending and unacknowledged. To reach it, the bench's responder acknowledges only the first few entries and then raises `init_req` in place of `wr_done`. It then checks that both timed intervals run again in full and that playback begins again at entry zero. Stray done pulses are injected during the release wait and after ready. Each of these is then judged by the length of the interval and the identity of the next request.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int SCRIPT_LEN = 18;
  localparam int ADDR_W     = 10;
  localparam int DATA_W     = 8;

  typedef struct packed {
    logic              is_long;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reg_write_t;

  typedef enum logic [1:0] {
    PH_HOLD   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_WRITE  = 2'd2,
    PH_READY  = 2'd3
  } phase_t;

  // cycles in one timed interval
  function automatic int interval_cycles(input longint clk_hz, input int usec);
    longint c;
    c = (clk_hz / 64'd1_000_000) * longint'(usec);
    if (c < 2) c = 2;
    return int'(c);
  endfunction

  function automatic reg_write_t mk(input logic lg, input logic [ADDR_W-1:0] a,
                                    input logic [DATA_W-1:0] d);
    reg_write_t w;
    w.is_long = lg;
    w.addr    = a;
    w.data    = d;
    return w;
  endfunction

  // start-up script; order matters (RF reset brackets the configuration)
  function automatic reg_write_t script_entry(input int idx);
    reg_write_t w;
    case (idx)
      0:  w = mk(1'b0, 10'h036, 8'h04);
      1:  w = mk(1'b0, 10'h036, 8'h00);
      2:  w = mk(1'b0, 10'h001, 8'hAA);
      3:  w = mk(1'b0, 10'h002, 8'hAA);
      4:  w = mk(1'b0, 10'h003, 8'hAA);
      5:  w = mk(1'b0, 10'h004, 8'hAA);
      6:  w = mk(1'b0, 10'h00D, 8'h01);
      7:  w = mk(1'b1, 10'h202, 8'h80);
      8:  w = mk(1'b1, 10'h203, 8'h00);
      9:  w = mk(1'b1, 10'h206, 8'h80);
      10: w = mk(1'b1, 10'h208, 8'h10);
      11: w = mk(1'b0, 10'h03A, 8'h78);
      12: w = mk(1'b0, 10'h03E, 8'h40);
      13: w = mk(1'b0, 10'h03F, 8'h00);
      14: w = mk(1'b1, 10'h200, 8'h00);
      15: w = mk(1'b0, 10'h000, 8'h01);
      16: w = mk(1'b0, 10'h036, 8'h04);
      17: w = mk(1'b0, 10'h036, 8'h00);
      default: w = mk(1'b0, '0, '0);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/rbs_interval_timer.sv
module rbs_interval_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || expired) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rbs_script_rom.sv
module rbs_script_rom
  import rbs_pkg::*;
#(
  parameter int DEPTH = SCRIPT_LEN
) (
  input  logic [$clog2(DEPTH)-1:0] idx,
  output reg_write_t               entry,
  output logic                     is_last
);
  localparam int IDX_W = $clog2(DEPTH);

  always_comb begin
    entry   = script_entry(int'(idx));
    is_last = (idx == IDX_W'(DEPTH - 1));
  end
endmodule

// File: rtl/radio_boot_seq.sv
module radio_boot_seq
  import rbs_pkg::*;
#(
  parameter longint CLK_HZ  = 100_000_000,
  parameter int     HOLD_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  output logic              xcvr_rst_n,
  output logic              xcvr_wake,
  output logic              wr_valid,
  output logic              wr_long,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_done,
  output logic              ready
);
  localparam int WAIT_CYC = interval_cycles(CLK_HZ, HOLD_US);
  localparam int IDX_W    = $clog2(SCRIPT_LEN);

  phase_t           phase;
  logic [IDX_W-1:0] step_idx;
  reg_write_t       cur_entry;

  // named internal events
  logic timer_run;
  logic timer_expired;
  logic step_accept;
  logic last_step;

  assign timer_run   = ((phase == PH_HOLD) || (phase == PH_SETTLE)) && !init_req;
  assign step_accept = wr_valid && wr_done;

  rbs_interval_timer #(.LIMIT(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (init_req),
    .run     (timer_run),
    .expired (timer_expired)
  );

  rbs_script_rom #(.DEPTH(SCRIPT_LEN)) u_rom (
    .idx     (step_idx),
    .entry   (cur_entry),
    .is_last (last_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HOLD;
      step_idx <= '0;
    end else if (init_req) begin
      phase    <= PH_HOLD;
      step_idx <= '0;
    end else begin
      case (phase)
        PH_HOLD:   if (timer_expired) phase <= PH_SETTLE;
        PH_SETTLE: if (timer_expired) phase <= PH_WRITE;
        PH_WRITE: begin
          if (step_accept) begin
            if (last_step) phase <= PH_READY;
            else           step_idx <= step_idx + 1'b1;
          end
        end
        default: phase <= PH_READY;
      endcase
    end
  end

  assign xcvr_rst_n = (phase != PH_HOLD);
  assign xcvr_wake  = 1'b1;
  assign wr_valid   = (phase == PH_WRITE);
  assign wr_long    = cur_entry.is_long;
  assign wr_addr    = cur_entry.addr;
  assign wr_data    = cur_entry.data;
  assign ready      = (phase == PH_READY);
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int WAIT_CYC = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       xcvr_rst_n,
  input logic       wr_valid,
  input logic       wr_long,
  input logic [9:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       wr_done,
  input logic       ready,
  input logic       step_accept,
  input logic       last_step
);
  int low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_cnt <= 0;
    else if (init_req)   low_cnt <= 0;
    else if (!xcvr_rst_n) low_cnt <= low_cnt + 1;
    else                 low_cnt <= 0;
  end

  // R1: hardware reset low window has the full length
  a_r1_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xcvr_rst_n) && !$past(init_req)) |-> (low_cnt == WAIT_CYC));

  // R2: no request while the transceiver is held in reset
  a_r2_no_write_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> xcvr_rst_n);

  // R3: pending request is held stable
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_done && !init_req) |=>
      (wr_valid && $stable(wr_long) && $stable(wr_addr) && $stable(wr_data)));

  // R6: ready follows completion of the final write and then persists
  a_r6_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (step_accept && last_step && !init_req) |=> ready);
  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !init_req) |=> ready);
  a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !wr_valid);

  // R7: restart request takes effect in the next cycle
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (!xcvr_rst_n && !ready && !wr_valid));
endmodule

bind radio_boot_seq rbs_checker #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_req    (init_req),
  .xcvr_rst_n  (xcvr_rst_n),
  .wr_valid    (wr_valid),
  .wr_long     (wr_long),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_done     (wr_done),
  .ready       (ready),
  .step_accept (step_accept),
  .last_step   (last_step)
);

// File: tb/radio_boot_seq_test.sv
module radio_boot_seq_test;
  localparam int W = 10000;  // 100 MHz * 100 us
  localparam int N = 18;

  // {long, addr[9:0], data[7:0]}
  localparam logic [18:0] VEC [N] = '{
    {1'b0, 10'h036, 8'h04}, {1'b0, 10'h036, 8'h00},
    {1'b0, 10'h001, 8'hAA}, {1'b0, 10'h002, 8'hAA},
    {1'b0, 10'h003, 8'hAA}, {1'b0, 10'h004, 8'hAA},
    {1'b0, 10'h00D, 8'h01}, {1'b1, 10'h202, 8'h80},
    {1'b1, 10'h203, 8'h00}, {1'b1, 10'h206, 8'h80},
    {1'b1, 10'h208, 8'h10}, {1'b0, 10'h03A, 8'h78},
    {1'b0, 10'h03E, 8'h40}, {1'b0, 10'h03F, 8'h00},
    {1'b1, 10'h200, 8'h00}, {1'b0, 10'h000, 8'h01},
    {1'b0, 10'h036, 8'h04}, {1'b0, 10'h036, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_req = 1'b0;
  logic       wr_done = 1'b0;
  logic       xcvr_rst_n, xcvr_wake, wr_valid, wr_long, ready;
  logic [9:0] wr_addr;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  radio_boot_seq uut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req),
    .xcvr_rst_n(xcvr_rst_n), .xcvr_wake(xcvr_wake),
    .wr_valid(wr_valid), .wr_long(wr_long), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_done(wr_done), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // count hold and settle intervals from the current negedge
  task automatic measure_boot(input bit stray_done);
    int lo = 0;
    int hi = 0;
    while (!xcvr_rst_n && lo < 3*W) begin
      chk(xcvr_wake == 1'b1, "R1 wake", int'(xcvr_wake), 1);
      chk(!wr_valid, "R2 no write in hold", int'(wr_valid), 0);
      lo++;
      @(negedge clk);
    end
    chk(lo == W, "R1 hold length", lo, W);
    while (xcvr_rst_n && !wr_valid && hi < 3*W) begin
      wr_done = (stray_done && hi == 7);  // R8 stray done in settle wait
      hi++;
      @(negedge clk);
    end
    wr_done = 1'b0;
    chk(hi == W, stray_done ? "R8 stray done ignored (settle)" : "R2 settle length", hi, W);
  endtask

  // answer `count` writes; leaves the next request (if any) presented
  task automatic run_script(input int count);
    for (int i = 0; i < count; i++) begin
      string tag;
      tag = (i < 2 || i >= N-2) ? "R5 RF reset pulse" : "R4 script entry";
      chk(wr_valid && !ready, "R3 request presented", int'(wr_valid), 1);
      chk({wr_long, wr_addr, wr_data} == VEC[i], tag,
          int'({wr_long, wr_addr, wr_data}), int'(VEC[i]));
      for (int k = 0; k < i % 3; k++) begin
        @(negedge clk);
        chk(wr_valid && {wr_long, wr_addr, wr_data} == VEC[i], "R3 held until done",
            int'({wr_long, wr_addr, wr_data}), int'(VEC[i]));
      end
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      if (i == N-1) begin
        chk(ready == 1'b1, "R6 ready after last", int'(ready), 1);
        chk(!wr_valid, "R6 no request when ready", int'(wr_valid), 0);
      end else if (i < N-1 && i == count-1) begin
        chk(!ready, "R6 ready low mid-script", int'(ready), 0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!ready, "R9 ready in reset", int'(ready), 0);
    chk(!wr_valid, "R9 valid in reset", int'(wr_valid), 0);
    chk(!xcvr_rst_n, "R9 hw reset in reset", int'(xcvr_rst_n), 0);
    chk(xcvr_wake, "R1 wake in reset", int'(xcvr_wake), 1);

    // power-on sequence with a stray done in the settle wait
    rst_n = 1'b1;
    measure_boot(1'b1);
    run_script(N);

    // R8 stray done after ready
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    repeat (20) @(negedge clk);
    chk(ready && !wr_valid, "R8 stray done after ready", int'(ready), 1);
    chk(ready, "R6 ready persists", int'(ready), 1);

    // R7 restart from ready
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    chk(!xcvr_rst_n && !ready && !wr_valid, "R7 restart from ready",
        int'({xcvr_rst_n, ready, wr_valid}), 0);
    measure_boot(1'b0);

    // R7 restart mid-script while entry 5 is pending
    run_script(5);
    chk({wr_long, wr_addr, wr_data} == VEC[5], "R3 next entry presented",
        int'({wr_long, wr_addr, wr_data}), int'(VEC[5]));
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    chk(!xcvr_rst_n && !ready && !wr_valid, "R7 restart mid-script",
        int'({xcvr_rst_n, ready, wr_valid}), 0);
    measure_boot(1'b0);
    chk({wr_long, wr_addr, wr_data} == VEC[0], "R7 script restarts at entry 0",
        int'({wr_long, wr_addr, wr_data}), int'(VEC[0]));
    run_script(N);
    repeat (5) @(negedge clk);
    chk(ready, "R6 ready after restarted script", int'(ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule